// File: doc/BRIEF.md
# Strobed Control Register Bank with Clock-Mode Decode

This block receives writes from a shared 8-bit parallel bus and holds three control bytes: a system byte, a monitor routing byte and a clock/routing byte. To write, a host drives a byte onto the data lines and pulls a shared active-low enable low. It then pulses one of three active-low select strobes. The rising edge of that strobe, once synchronised to the system clock, copies the byte into the selected register. The copy happens only if the enable is low at that point.

The clock/routing byte is split into separate control outputs:
- a 3-bit rate code, bits 2:0;
- an internal/external sync select, bit 3;
- a word-clock multiple select, bit 4;
- a coax source select, bit 5;
- two capture source selects, bits 6 and 7.

With sync select clear, the rate code chooses one of six internal sample rates, and the block gives that rate in hertz. With sync select set, the same code together with the word-clock bit selects an external clock type. The rate output and the decoded external mode each keep their last valid value when a write carries an undefined combination. In that case the block raises a flag for the condition.

Top module: `ctl_bank`

## Requirements
- R1: After reset, all three registers read 0x00, rate_hz is 44100, ext_mode is 0 (internal), and rate_bad and mode_bad are 0.
- R2: A rising edge on a select strobe while bus_oe_n is low copies bus_d into that register only. The new value appears on the outputs no later than 4 clock cycles after the edge.
- R3: A strobe pulse while bus_oe_n is high changes no register and no decoded output.
- R4: mon_route follows the monitor byte bit for bit. Bit 0 enables in1/2 to mon1/2, bit 1 in1/2 to mon3/4, bit 2 in3/4 to mon1/2, bit 3 in3/4 to mon3/4, bit 4 out3/4 to mon1/2, and bit 5 out1/2 to mon3/4. Bits 7:6 are stored as written.
- R5: The clock byte drives these outputs: rate_code from bits 2:0, sync_ext from bit 3 (1 = external), wc_256 from bit 4 (1 = 256×fs), coax_i2s from bit 5 (1 = I2S, 0 = S/PDIF), in12_alt from bit 6 and in34_alt from bit 7.
- R6: A clock byte with sync_ext clear and rate code 0..5 sets rate_hz to 44100, 48000, 88200, 96000, 176400 or 192000 for codes 0 to 5 in that order. It also clears rate_bad, sets ext_mode to 0 and clears mode_bad.
- R7: A clock byte with sync_ext clear and rate code 6 or 7 sets rate_bad and leaves rate_hz unchanged.
- R8: A clock byte with sync_ext set selects ext_mode as follows: 1 (S/PDIF) for code 0 with bit 4 clear, 2 (word clock 1×fs) for code 2 with bit 4 clear, and 3 (word clock 256×fs) for code 2 with bit 4 set. Any of these clears mode_bad.
- R9: A clock byte with sync_ext set that matches none of the three external modes sets mode_bad and leaves ext_mode unchanged.
- R10: A clock byte with sync_ext set leaves rate_hz unchanged and clears rate_bad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_d | input | 8 | Shared write data |
| bus_oe_n | input | 1 | Active-low write enable shared by all strobes |
| sel_sys_n | input | 1 | Active-low strobe, system byte |
| sel_mon_n | input | 1 | Active-low strobe, monitor byte |
| sel_clk_n | input | 1 | Active-low strobe, clock/routing byte |
| sys_ctl | output | 8 | Stored system byte |
| mon_route | output | 8 | Stored monitor byte, bits 5:0 are route enables |
| rate_code | output | 3 | Raw rate code field |
| sync_ext | output | 1 | External sync selected |
| wc_256 | output | 1 | Word clock is 256×fs |
| coax_i2s | output | 1 | Coax output carries I2S |
| in12_alt | output | 1 | Input 1/2 alternate source |
| in34_alt | output | 1 | Input 3/4 alternate source |
| rate_hz | output | 18 | Last valid internal sample rate in hertz |
| rate_bad | output | 1 | Last internal-sync write had rate code 6 or 7 |
| ext_mode | output | 2 | 0 internal, 1 S/PDIF, 2 word clock 1×fs, 3 word clock 256×fs |
| mode_bad | output | 1 | Last external-sync write was undefined |

## Verification
Writes go in through the three strobes with random bytes and random enable states, so the bench can tell whether a byte landed in the wrong register, landed while the enable was high, or failed to land. Directed clock bytes step through all eight rate codes with sync clear. This separates the six legal rates from the two codes that must leave the rate unchanged. With sync set, the bench writes the three legal external combinations and then undefined ones, such as code 1 or code 0 with the 256×fs bit set. These show whether the mode is held rather than overwritten, and whether the rate stays frozen while external sync is selected.

// File: rtl/ctlbank_pkg.sv
package ctlbank_pkg;

  localparam int BUS_W    = 8;
  localparam int NUM_REGS = 3;
  localparam int HZ_W     = 18;

  localparam int IDX_SYS = 0;
  localparam int IDX_MON = 1;
  localparam int IDX_CLK = 2;

  localparam int CODE_LSB  = 0;
  localparam int CODE_W    = 3;
  localparam int SYNC_BIT  = 3;
  localparam int WORD_BIT  = 4;
  localparam int COAX_BIT  = 5;
  localparam int IN12_BIT  = 6;
  localparam int IN34_BIT  = 7;
  localparam int MAX_RATE_CODE = 5;

  typedef enum logic [1:0] {
    EXT_NONE  = 2'd0,
    EXT_SPDIF = 2'd1,
    EXT_WC1   = 2'd2,
    EXT_WC256 = 2'd3
  } ext_mode_e;

  typedef struct packed {
    logic      ok;
    ext_mode_e mode;
  } ext_dec_t;

  function automatic logic rate_code_ok(input logic [CODE_W-1:0] code);
    return code <= CODE_W'(MAX_RATE_CODE);
  endfunction

  function automatic logic [HZ_W-1:0] rate_hz_of(input logic [CODE_W-1:0] code);
    logic [HZ_W-1:0] hz;
    case (code)
      3'd0:    hz = HZ_W'(44100);
      3'd1:    hz = HZ_W'(48000);
      3'd2:    hz = HZ_W'(88200);
      3'd3:    hz = HZ_W'(96000);
      3'd4:    hz = HZ_W'(176400);
      3'd5:    hz = HZ_W'(192000);
      default: hz = HZ_W'(44100);
    endcase
    return hz;
  endfunction

  function automatic ext_dec_t ext_decode(input logic [CODE_W-1:0] code,
                                          input logic word);
    ext_dec_t r;
    r.ok   = 1'b0;
    r.mode = EXT_NONE;
    if (code == 3'd0 && !word) begin
      r.ok   = 1'b1;
      r.mode = EXT_SPDIF;
    end else if (code == 3'd2) begin
      r.ok   = 1'b1;
      r.mode = word ? EXT_WC256 : EXT_WC1;
    end
    return r;
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int NUM_STRB    = 3,
  parameter int SYNC_STAGES = 2,
  parameter int DW          = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_STRB-1:0] strb_n,
  input  logic                oe_n,
  input  logic [DW-1:0]       data,
  output logic [NUM_STRB-1:0] rise,
  output logic                oe_s_n,
  output logic [DW-1:0]       data_s
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_STRB-1:0] st_q  [SYNC_STAGES+1];
  logic                oe_q  [SYNC_STAGES];
  logic [DW-1:0]       d_q   [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= SYNC_STAGES; i++) st_q[i] <= '1;
      for (int i = 0; i < SYNC_STAGES; i++) begin
        oe_q[i] <= 1'b1;
        d_q[i]  <= '0;
      end
    end else begin
      st_q[0] <= strb_n;
      oe_q[0] <= oe_n;
      d_q[0]  <= data;
      for (int i = 1; i <= SYNC_STAGES; i++) st_q[i] <= st_q[i-1];
      for (int i = 1; i < SYNC_STAGES; i++) begin
        oe_q[i] <= oe_q[i-1];
        d_q[i]  <= d_q[i-1];
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_STRB; g++) begin : g_edge
      assign rise[g] = st_q[LAST][g] & ~st_q[LAST+1][g];
    end
  endgenerate

  assign oe_s_n = oe_q[LAST];
  assign data_s = d_q[LAST];

endmodule

// File: rtl/reg_file.sv
module reg_file #(
  parameter int NUM = 3,
  parameter int DW  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM-1:0]         rise,
  input  logic                   oe_s_n,
  input  logic [DW-1:0]          data_s,
  output logic [NUM-1:0]         ld,
  output logic [NUM-1:0][DW-1:0] regs
);

  assign ld = rise & {NUM{~oe_s_n}};

  genvar g;
  generate
    for (g = 0; g < NUM; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     regs[g] <= '0;
        else if (ld[g]) regs[g] <= data_s;
      end
    end
  endgenerate

endmodule

// File: rtl/clk_decode.sv
module clk_decode
  import ctlbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [BUS_W-1:0] din,
  output logic [HZ_W-1:0]  rate_hz,
  output logic             rate_bad,
  output ext_mode_e        ext_mode,
  output logic             mode_bad
);

  logic [CODE_W-1:0] code;
  logic              sync_sel;
  ext_dec_t          dec;

  assign code     = din[CODE_LSB +: CODE_W];
  assign sync_sel = din[SYNC_BIT];

  always_comb dec = ext_decode(code, din[WORD_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_hz  <= rate_hz_of('0);
      rate_bad <= 1'b0;
      ext_mode <= EXT_NONE;
      mode_bad <= 1'b0;
    end else if (ld) begin
      if (!sync_sel) begin
        rate_bad <= !rate_code_ok(code);
        if (rate_code_ok(code)) rate_hz <= rate_hz_of(code);
        ext_mode <= EXT_NONE;
        mode_bad <= 1'b0;
      end else begin
        rate_bad <= 1'b0;
        mode_bad <= !dec.ok;
        if (dec.ok) ext_mode <= dec.mode;
      end
    end
  end

endmodule

// File: rtl/ctl_bank.sv
module ctl_bank
  import ctlbank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_d,
  input  logic        bus_oe_n,
  input  logic        sel_sys_n,
  input  logic        sel_mon_n,
  input  logic        sel_clk_n,
  output logic [7:0]  sys_ctl,
  output logic [7:0]  mon_route,
  output logic [2:0]  rate_code,
  output logic        sync_ext,
  output logic        wc_256,
  output logic        coax_i2s,
  output logic        in12_alt,
  output logic        in34_alt,
  output logic [17:0] rate_hz,
  output logic        rate_bad,
  output logic [1:0]  ext_mode,
  output logic        mode_bad
);

  logic [NUM_REGS-1:0]            strb_n;
  logic [NUM_REGS-1:0]            rise_vec;
  logic [NUM_REGS-1:0]            ld_vec;
  logic                           oe_s_n;
  logic [BUS_W-1:0]               data_s;
  logic [NUM_REGS-1:0][BUS_W-1:0] regs;
  ext_mode_e                      mode_q;
  logic [BUS_W-1:0]               clk_byte;

  assign strb_n[IDX_SYS] = sel_sys_n;
  assign strb_n[IDX_MON] = sel_mon_n;
  assign strb_n[IDX_CLK] = sel_clk_n;

  strobe_sync #(
    .NUM_STRB   (NUM_REGS),
    .SYNC_STAGES(SYNC_STAGES),
    .DW         (BUS_W)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .strb_n(strb_n),
    .oe_n  (bus_oe_n),
    .data  (bus_d),
    .rise  (rise_vec),
    .oe_s_n(oe_s_n),
    .data_s(data_s)
  );

  reg_file #(
    .NUM(NUM_REGS),
    .DW (BUS_W)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .rise  (rise_vec),
    .oe_s_n(oe_s_n),
    .data_s(data_s),
    .ld    (ld_vec),
    .regs  (regs)
  );

  clk_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (ld_vec[IDX_CLK]),
    .din     (data_s),
    .rate_hz (rate_hz),
    .rate_bad(rate_bad),
    .ext_mode(mode_q),
    .mode_bad(mode_bad)
  );

  assign clk_byte  = regs[IDX_CLK];
  assign sys_ctl   = regs[IDX_SYS];
  assign mon_route = regs[IDX_MON];
  assign rate_code = clk_byte[CODE_LSB +: CODE_W];
  assign sync_ext  = clk_byte[SYNC_BIT];
  assign wc_256    = clk_byte[WORD_BIT];
  assign coax_i2s  = clk_byte[COAX_BIT];
  assign in12_alt  = clk_byte[IN12_BIT];
  assign in34_alt  = clk_byte[IN34_BIT];
  assign ext_mode  = mode_q;

endmodule

// File: rtl/ctl_bank_chk.sv
module ctl_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  ld_vec,
  input logic        oe_s_n,
  input logic [7:0]  data_s,
  input logic [7:0]  sys_ctl,
  input logic [17:0] rate_hz,
  input logic        rate_bad,
  input logic [1:0]  ext_mode,
  input logic        mode_bad,
  input logic        sync_ext
);

  logic clk_int_badcode;
  logic clk_ext_undef;

  assign clk_int_badcode = ld_vec[2] && !data_s[3] && (data_s[2:0] > 3'd5);
  assign clk_ext_undef   = ld_vec[2] && data_s[3] &&
                           !((data_s[2:0] == 3'd0 && !data_s[4]) ||
                             (data_s[2:0] == 3'd2));

  // R2
  sys_only_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sys_ctl) |-> $past(ld_vec[0]));

  // R3
  load_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vec != 3'b000) |-> !oe_s_n);

  // R6
  rate_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_hz inside {18'd44100, 18'd48000, 18'd88200, 18'd96000, 18'd176400, 18'd192000});

  // R7
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_int_badcode |=> ($stable(rate_hz) && rate_bad));

  // R8
  ext_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode != 2'd0) |-> sync_ext);

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_ext_undef |=> ($stable(ext_mode) && mode_bad));

  // R10
  rate_frozen_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vec[2] && data_s[3]) |=> ($stable(rate_hz) && !rate_bad));

endmodule

bind ctl_bank ctl_bank_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ld_vec  (ld_vec),
  .oe_s_n  (oe_s_n),
  .data_s  (data_s),
  .sys_ctl (sys_ctl),
  .rate_hz (rate_hz),
  .rate_bad(rate_bad),
  .ext_mode(ext_mode),
  .mode_bad(mode_bad),
  .sync_ext(sync_ext)
);

// File: tb/test_ctl_bank.sv
module test_ctl_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_d = 8'h00;
  logic        bus_oe_n = 1'b1;
  logic [2:0]  strb_n = 3'b111;
  logic [7:0]  sys_ctl, mon_route;
  logic [2:0]  rate_code;
  logic        sync_ext, wc_256, coax_i2s, in12_alt, in34_alt;
  logic [17:0] rate_hz;
  logic        rate_bad, mode_bad;
  logic [1:0]  ext_mode;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  logic [7:0]  m_sys = 0, m_mon = 0, m_clk = 0;
  logic [17:0] m_hz = 18'd44100;
  logic        m_rbad = 0, m_mbad = 0;
  logic [1:0]  m_mode = 0;

  always #10 clk = ~clk;

  ctl_bank i_ctl_bank (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .bus_oe_n(bus_oe_n),
    .sel_sys_n(strb_n[0]), .sel_mon_n(strb_n[1]), .sel_clk_n(strb_n[2]),
    .sys_ctl(sys_ctl), .mon_route(mon_route), .rate_code(rate_code),
    .sync_ext(sync_ext), .wc_256(wc_256), .coax_i2s(coax_i2s),
    .in12_alt(in12_alt), .in34_alt(in34_alt), .rate_hz(rate_hz),
    .rate_bad(rate_bad), .ext_mode(ext_mode), .mode_bad(mode_bad)
  );

  // rate in hertz built from base rate and a power-of-two multiplier
  function automatic logic [17:0] exp_hz(input logic [2:0] c);
    int base;
    base = c[0] ? 48000 : 44100;
    return 18'(base * (1 << c[2:1]));
  endfunction

  // expected external mode, returns 0 for an undefined combination
  function automatic logic [2:0] exp_ext(input logic [2:0] c, input logic w);
    if (c == 3'd2) return w ? 3'b111 : 3'b110;
    if (c == 3'd0 && w == 1'b0) return 3'b101;
    return 3'b000;
  endfunction

  task automatic model_write(input int which, input logic [7:0] d);
    logic [2:0] e;
    if (which == 0) m_sys = d;
    else if (which == 1) m_mon = d;
    else begin
      m_clk = d;
      if (d[3] == 1'b0) begin
        m_mode = 2'd0;
        m_mbad = 1'b0;
        if (d[2:0] >= 3'd6) m_rbad = 1'b1;
        else begin
          m_rbad = 1'b0;
          m_hz   = exp_hz(d[2:0]);
        end
      end else begin
        m_rbad = 1'b0;
        e = exp_ext(d[2:0], d[4]);
        if (e[2]) begin
          m_mode = e[1:0];
          m_mbad = 1'b0;
        end else m_mbad = 1'b1;
      end
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic check_all(input string ctx);
    chk({ctx, " R2 sys_ctl"}, 32'(sys_ctl), 32'(m_sys));
    chk({ctx, " R4 mon_route"}, 32'(mon_route), 32'(m_mon));
    chk({ctx, " R5 fields"},
        {20'd0, in34_alt, in12_alt, coax_i2s, wc_256, sync_ext, rate_code, 4'd0},
        {20'd0, m_clk, 4'd0});
    chk({ctx, " R6 rate_hz"}, 32'(rate_hz), 32'(m_hz));
    chk({ctx, " R7 rate_bad"}, 32'(rate_bad), 32'(m_rbad));
    chk({ctx, " R8 ext_mode"}, 32'(ext_mode), 32'(m_mode));
    chk({ctx, " R9 mode_bad"}, 32'(mode_bad), 32'(m_mbad));
  endtask

  task automatic bus_write(input int which, input logic [7:0] d, input bit en);
    @(negedge clk);
    bus_d    = d;
    bus_oe_n = ~en;
    @(negedge clk);
    strb_n[which] = 1'b0;
    repeat (2) @(negedge clk);
    strb_n[which] = 1'b1;
    repeat (4) @(negedge clk);
    bus_oe_n = 1'b1;
    bus_d    = 8'($urandom);
    repeat (2) @(negedge clk);
    if (en) model_write(which, d);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h0000_5EED);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1 reset");

    bus_write(0, 8'hA5, 1'b1); check_all("R2 sys write");
    bus_write(1, 8'h3C, 1'b1); check_all("R4 mon write");
    bus_write(1, 8'hC3, 1'b1); check_all("R4 mon write spare bits");
    bus_write(2, 8'hE0, 1'b1); check_all("R5 routing bits");

    // R3: strobes with enable high leave everything as is
    for (int k = 0; k < 3; k++) begin
      bus_write(k, 8'h5A, 1'b0);
      check_all("R3 enable high ignored");
    end

    // R6 / R7: all rate codes with internal sync
    for (int c = 0; c < 8; c++) begin
      bus_write(2, 8'(c), 1'b1);
      check_all(c >= 6 ? "R7 bad rate code" : "R6 rate code");
    end
    bus_write(2, 8'h03, 1'b1); check_all("R6 96k");
    bus_write(2, 8'h07, 1'b1); check_all("R7 code 7 holds 96k");

    // R8: the three external modes, R10 rate frozen
    bus_write(2, 8'h08, 1'b1); check_all("R8 spdif R10");
    bus_write(2, 8'h0A, 1'b1); check_all("R8 wc1");
    bus_write(2, 8'h1A, 1'b1); check_all("R8 wc256");
    // R9: undefined external combos hold mode
    bus_write(2, 8'h09, 1'b1); check_all("R9 code1 ext");
    bus_write(2, 8'h18, 1'b1); check_all("R9 code0 word ext");
    bus_write(2, 8'h0F, 1'b1); check_all("R9 code7 ext R10");
    bus_write(2, 8'h02, 1'b1); check_all("R6 back to internal");

    for (int n = 0; n < 250; n++) begin
      int which;
      logic [7:0] d;
      bit en;
      which = int'($urandom % 3);
      d     = 8'($urandom);
      en    = ($urandom % 5) != 0;
      bus_write(which, d, en);
      check_all(en ? "R2 random write" : "R3 random ignored");
    end

    finish_run();
  end

endmodule